// File: doc/BRIEF.md
# Dual-Bank Clock Configuration Switcher

This block produces a divided output clock from one of several source clock ticks. It keeps two complete configuration banks. Each bank holds a source choice, a pre-divider, a fractional M/N stage with its own enable and counter-reset bits, and the M and N values. A single select bit in a control register names the active bank. Every source is given as a one-cycle tick in the core clock domain. The output appears as a one-cycle `outPulse` per output edge and as a level `outClk` that toggles on each pulse.

Software reprograms a running clock in three steps. It writes the idle bank, holding its counter reset while M and N change. It then releases the counter reset. Finally it flips the select bit. The hardware applies the flip only at the next output pulse of the old configuration. It then restarts its counters and spends the first source tick on alignment, so the clock never sees a half-written bank and never emits a shortened gap. While the output is disabled, the selected bank is rewritten in place and a select change applies at once.

A parameter `MODE_IN_CTRL` chooses where each bank's M/N enable bit lives. When it is 0, the bit sits in the bank's configuration word. When it is 1, the enable bits for both banks sit in the control register.

Top module: `dual_bank_clk_switch`

## Requirements
- R1: After reset, bank 0 is active and holds source 0, divide-by-1 and the M/N stage off. `outPulse` and `outClk` are 0.
- R2: Register map, with `wrAddr` decoded in full:
  - Address 0 is bank 0 config and address 1 is bank 1 config. Fields: source in bits [1:0], pre-divider minus one in [5:2], M/N enable in bit 6, M/N counter reset in bit 7.
  - Address 2 is bank 0 M/N and address 3 is bank 1 M/N, with M in [7:0] and N in [15:8].
  - Address 4 is control, with the bank select in bit 0.
- R3: With M/N off, successive output pulses are spaced by the source tick period times (pre-divider + 1) core cycles. With M/N on, M = 1 and N = k, the spacing is k times that.
- R4: `outClk` inverts on every output pulse. While `outEn` is 0, `outPulse` and `outClk` stay 0.
- R5: While `outEn` is 1, writes to the idle bank leave the output spacing unchanged until the select bit is written.
- R6: While `outEn` is 1, a new select takes effect at the next output pulse of the old bank. The counters then restart, and the first source tick after the switch only aligns. No gap around the switch is shorter than the smaller of the old and new spacings.
- R7: While `outEn` is 1, writes to the active bank, or to a bank awaiting activation, are ignored.
- R8: While `outEn` is 0, writes to the selected bank take effect in place, and a select change takes effect on the next clock edge.
- R9: While a bank's M/N stage is enabled and its counter-reset bit is 1, that bank produces no output pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTick | input | NSRC | One-cycle tick per source clock edge |
| outEn | input | 1 | Output enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | AW | Register address |
| wrData | input | DW | Register write data |
| outPulse | output | 1 | One-cycle pulse per output edge |
| outClk | output | 1 | Output clock level, toggles per pulse |

## Verification
Register writes take effect on the next core edge. An internal pulse reaches `outPulse` and `outClk` one cycle later. A select flip waits for one old-bank pulse and then one alignment tick, so the new spacing only settles from the second new pulse. The bench therefore drives inputs just after the falling edge and samples outputs on falling edges. After each select write it lets three pulses pass before measuring a gap. A monitor watches every gap in the window around the flip and compares it against the smaller of the old and new spacings.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  // Strobes from the bank control to the divider datapath.
  typedef struct packed {
    logic clearCnt;  // restart pre-divider, alignment and M/N accumulator
    logic holdOut;   // output disabled: no ticks, output level forced low
  } swStrobe_t;
endpackage

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int PDW = 4,
  parameter int MNW = 8,
  parameter int MODE_IN_CTRL = 0,
  parameter int AW = 3,
  parameter int DW = 16,
  localparam int SRCW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            outEn,
  input  logic            wrEn,
  input  logic [AW-1:0]   wrAddr,
  input  logic [DW-1:0]   wrData,
  input  logic            pulseNow,
  output swStrobe_t       strobe,
  output logic [SRCW-1:0] actSrc,
  output logic [PDW-1:0]  actPd,
  output logic            actMnEn,
  output logic            actMnRst,
  output logic [MNW-1:0]  actM,
  output logic [MNW-1:0]  actN
);
  localparam int PD_LSB    = SRCW;
  localparam int MNEN_BIT  = SRCW + PDW;
  localparam int MNRST_BIT = MNEN_BIT + 1;
  localparam int CFGW      = MNRST_BIT + 1;
  localparam int MNRW      = 2 * MNW;
  localparam int CTRL_ADDR = 4;

  logic [CFGW-1:0] cfgReg [2];
  logic [MNRW-1:0] mnReg [2];
  logic [1:0]      locked;
  logic            selReq, actSel, swapNow;
  logic            ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == AW'(CTRL_ADDR));

  // A bank is frozen while the clock runs if it is live or about to be.
  always_comb begin
    for (int b = 0; b < 2; b++) begin
      locked[b] = outEn && ((actSel == 1'(b)) || (selReq == 1'(b)));
    end
  end

  for (genvar g = 0; g < 2; g++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgReg[g] <= '0;
        mnReg[g]  <= '0;
      end else if (wrEn && !locked[g]) begin
        if (wrAddr == AW'(g))     cfgReg[g] <= wrData[CFGW-1:0];
        if (wrAddr == AW'(2 + g)) mnReg[g]  <= wrData[MNRW-1:0];
      end
    end
  end

  if (MODE_IN_CTRL != 0) begin : gModeCtrl
    logic [1:0] ctrlMode;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlMode <= '0;
      end else if (ctrlWr) begin
        for (int b = 0; b < 2; b++) begin
          if (!locked[b]) ctrlMode[b] <= wrData[1 + b];
        end
      end
    end
    assign actMnEn = ctrlMode[actSel];
  end else begin : gModeCfg
    assign actMnEn = cfgReg[actSel][MNEN_BIT];
  end

  // Switch only on an output pulse of the old bank, or at once when idle.
  assign swapNow = (selReq != actSel) && (pulseNow || !outEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReq <= 1'b0;
      actSel <= 1'b0;
    end else begin
      if (ctrlWr)  selReq <= wrData[0];
      if (swapNow) actSel <= selReq;
    end
  end

  assign strobe.clearCnt = swapNow || !outEn;
  assign strobe.holdOut  = !outEn;

  assign actSrc   = cfgReg[actSel][SRCW-1:0];
  assign actPd    = cfgReg[actSel][PD_LSB +: PDW];
  assign actMnRst = cfgReg[actSel][MNRST_BIT];
  assign actM     = mnReg[actSel][MNW-1:0];
  assign actN     = mnReg[actSel][MNW +: MNW];

  // R6
  swap_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actSel != $past(actSel)) |-> ($past(pulseNow) || !$past(outEn)));

  // R7
  locked_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && outEn && (wrAddr == AW'(actSel)) && !swapNow)
      |=> ($stable(actPd) && $stable(actSrc) && $stable(actMnRst)));

  // R8
  idle_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outEn && (selReq != actSel)) |=> (actSel == $past(selReq)));
endmodule

// File: rtl/clksw_datapath.sv
module clksw_datapath
  import clksw_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int PDW = 4,
  parameter int MNW = 8,
  localparam int SRCW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcTick,
  input  swStrobe_t       strobe,
  input  logic [SRCW-1:0] src,
  input  logic [PDW-1:0]  pd,
  input  logic            mnEn,
  input  logic            mnRst,
  input  logic [MNW-1:0]  mVal,
  input  logic [MNW-1:0]  nVal,
  output logic            pulseNow,
  output logic            outPulse,
  output logic            outClk
);
  logic           tick, pdWrap, alignDone, hit;
  logic [PDW-1:0] pdCnt;
  logic [MNW-1:0] acc;
  logic [MNW:0]   sum;

  assign tick   = srcTick[src] && !strobe.holdOut;
  assign pdWrap = tick && alignDone && (pdCnt >= pd);
  assign sum    = {1'b0, acc} + {1'b0, mVal};
  assign hit    = sum >= {1'b0, nVal};
  assign pulseNow = pdWrap && (!mnEn || (!mnRst && hit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alignDone <= 1'b0;
      pdCnt     <= '0;
      acc       <= '0;
    end else if (strobe.clearCnt) begin
      alignDone <= 1'b0;
      pdCnt     <= '0;
      acc       <= '0;
    end else begin
      if (tick && !alignDone) alignDone <= 1'b1;
      if (tick && alignDone)  pdCnt <= pdWrap ? '0 : pdCnt + 1'b1;
      if (mnRst || !mnEn)     acc <= '0;
      else if (pdWrap)        acc <= hit ? MNW'(sum - {1'b0, nVal}) : sum[MNW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPulse <= 1'b0;
      outClk   <= 1'b0;
    end else begin
      outPulse <= pulseNow;
      outClk   <= strobe.holdOut ? 1'b0 : (outClk ^ pulseNow);
    end
  end

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.holdOut |=> (!outPulse && !outClk));

  // R4
  clk_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outClk != $past(outClk)) |-> (outPulse || $past(strobe.holdOut)));

  // R9
  mn_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mnEn && mnRst) |=> !outPulse);
endmodule

// File: rtl/dual_bank_clk_switch.sv
module dual_bank_clk_switch
  import clksw_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int PDW = 4,
  parameter int MNW = 8,
  parameter int MODE_IN_CTRL = 0,
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcTick,
  input  logic            outEn,
  input  logic            wrEn,
  input  logic [AW-1:0]   wrAddr,
  input  logic [DW-1:0]   wrData,
  output logic            outPulse,
  output logic            outClk
);
  localparam int SRCW = $clog2(NSRC);

  swStrobe_t       strobe;
  logic [SRCW-1:0] actSrc;
  logic [PDW-1:0]  actPd;
  logic            actMnEn, actMnRst, pulseNow;
  logic [MNW-1:0]  actM, actN;

  clksw_ctrl #(
    .NSRC(NSRC), .PDW(PDW), .MNW(MNW), .MODE_IN_CTRL(MODE_IN_CTRL), .AW(AW), .DW(DW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .outEn(outEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pulseNow(pulseNow), .strobe(strobe), .actSrc(actSrc),
    .actPd(actPd), .actMnEn(actMnEn), .actMnRst(actMnRst), .actM(actM), .actN(actN)
  );

  clksw_datapath #(
    .NSRC(NSRC), .PDW(PDW), .MNW(MNW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .strobe(strobe), .src(actSrc),
    .pd(actPd), .mnEn(actMnEn), .mnRst(actMnRst), .mVal(actM), .nVal(actN),
    .pulseNow(pulseNow), .outPulse(outPulse), .outClk(outClk)
  );
endmodule

// File: tb/dual_bank_clk_switch_tb_top.sv
module dual_bank_clk_switch_tb_top;
  localparam int NSRC = 4;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int PER [NSRC] = '{1, 2, 3, 5};
  // src, pre-div field, mnEn, M, N, expected gap
  localparam int VEC [6][6] = '{
    '{1, 0, 0, 0, 0, 2},
    '{2, 1, 0, 0, 0, 6},
    '{3, 0, 1, 1, 2, 10},
    '{0, 3, 0, 0, 0, 4},
    '{1, 2, 1, 1, 3, 18},
    '{0, 0, 0, 0, 0, 1}
  };

  logic clk = 1'b0, rstN = 1'b0, outEn = 1'b0, wrEn = 1'b0;
  logic [NSRC-1:0] srcTick = '0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic outPulse, outClk;

  int checks = 0, errors = 0;
  int cyc = 0;
  int monOn = 0, monMin = 0, runtHit = 0, sinceLast = 0, havePrev = 0;

  always #10 clk = ~clk;

  dual_bank_clk_switch dut_i (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .outEn(outEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .outPulse(outPulse), .outClk(outClk)
  );

  initial forever begin
    @(negedge clk);
    #1;
    for (int i = 0; i < NSRC; i++) srcTick[i] = ((cyc % PER[i]) == 0);
    cyc++;
  end

  // Gap monitor for the switch window (R6)
  initial forever begin
    @(negedge clk);
    if (!outEn) havePrev = 0;
    sinceLast++;
    if (outPulse) begin
      if (havePrev != 0 && monOn != 0 && sinceLast < monMin) runtHit = 1;
      sinceLast = 0;
      havePrev = 1;
    end
  end

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] cfgW(int s, int p, int e, int r);
    return DW'(s | (p << 2) | (e << 6) | (r << 7));
  endfunction

  function automatic logic [DW-1:0] mnW(int m, int n);
    return DW'(m | (n << 8));
  endfunction

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk); #1;
    wrEn = 1'b1; wrAddr = AW'(a); wrData = d;
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic setEn(logic v);
    @(negedge clk); #1;
    outEn = v;
  endtask

  task automatic waitPulse();
    int t = 0;
    do begin @(negedge clk); t++; end while (!outPulse && t < 1000);
  endtask

  task automatic measure(output int g);
    waitPulse();
    g = 0;
    do begin @(negedge clk); g++; end while (!outPulse && g < 1000);
  endtask

  task automatic countPulses(int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (outPulse) p++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int g, p, a, b, prev, cur, tgt, mn;
    repeat (3) @(negedge clk);
    chk("R1 outPulse in reset", int'(outPulse), 0);
    chk("R1 outClk in reset", int'(outClk), 0);
    #1 rstN = 1'b1;
    countPulses(20, p);
    chk("R4 no pulses while disabled", p, 0);
    chk("R4 outClk low while disabled", int'(outClk), 0);
    setEn(1'b1);
    measure(g);
    chk("R1 reset bank gap", g, 1);
    waitPulse(); a = int'(outClk);
    waitPulse(); b = int'(outClk);
    chk("R4 outClk inverts per pulse", int'(a != b), 1);

    // Vector walk: program idle bank (fields per R2), then flip select
    prev = 1; cur = 0;
    for (int v = 0; v < 6; v++) begin
      tgt = 1 - cur;
      wr(tgt, cfgW(VEC[v][0], VEC[v][1], VEC[v][2], 1));
      wr(2 + tgt, mnW(VEC[v][3], VEC[v][4]));
      wr(tgt, cfgW(VEC[v][0], VEC[v][1], VEC[v][2], 0));
      measure(g);
      chk("R5 idle bank write leaves gap", g, prev);
      mn = (prev < VEC[v][5]) ? prev : VEC[v][5];
      monMin = mn; runtHit = 0; monOn = 1;
      wr(4, DW'(tgt));
      repeat (3) waitPulse();
      measure(g);
      chk("R3 gap after switch", g, VEC[v][5]);
      monOn = 0;
      chk("R6 no short gap across switch", runtHit, 0);
      prev = VEC[v][5]; cur = tgt;
    end

    // R7: active bank (0) is frozen while running
    wr(0, cfgW(0, 7, 0, 0));
    repeat (4) @(negedge clk);
    measure(g);
    chk("R7 active bank write ignored", g, 1);

    // R8: in-place rewrite while disabled
    setEn(1'b0);
    wr(0, cfgW(0, 2, 0, 0));
    setEn(1'b1);
    measure(g);
    chk("R8 in-place rewrite", g, 3);

    // R8: select change while disabled applies immediately (bank 1 = 18)
    setEn(1'b0);
    wr(4, DW'(1));
    setEn(1'b1);
    measure(g);
    chk("R8 idle select change", g, 18);

    // R9: counter reset holds the M/N stage
    setEn(1'b0);
    wr(3, mnW(1, 2));
    wr(1, cfgW(0, 0, 1, 1));
    setEn(1'b1);
    countPulses(40, p);
    chk("R9 no pulses under counter reset", p, 0);
    setEn(1'b0);
    wr(1, cfgW(0, 0, 1, 0));
    setEn(1'b1);
    measure(g);
    chk("R9 released counter gap", g, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule